// File: doc/BRIEF.md
# Unified TLB Address Translator

This block turns a 32-bit data virtual address into a 29-bit physical address. Two fixed windows of the address space are never translated. The first covers 0x80000000 to 0xBFFFFFFF. The second covers everything from 0xE0000000 upward. Addresses in these windows drop their three top bits. A user-mode access that lands in them faults, unless it falls inside the store-queue window. When translation is switched off, every other address passes through the same way. When translation is on, the address is compared in parallel against a fully associative table of translation entries. Each entry carries an address-space tag, a page size, a two-bit access code and a dirty flag.

A request is presented for one cycle. The result appears on the next cycle, as one of two outcomes:
- a success flag with the physical address;
- a 12-bit exception code, with the faulting virtual address captured in a holding register.

Every lookup that reaches the table also advances a replacement counter. Software reads this counter to choose a victim slot when it refills the table. Software fills slots through a direct write port, and misses are resolved by software.

Top module: `utlb_xlate`

## Requirements
- R1: After reset, `rsp_valid`, `urc` and `tea` are 0 and every table slot is invalid, so a translated lookup misses.
- R2: In privileged mode (`req_priv`=1), an address in 0x80000000..0xBFFFFFFF or at or above 0xE0000000 succeeds with `rsp_pa` = `req_va[28:0]`. The result appears one cycle after the request, with `rsp_ok`=1 and `rsp_exc`=0x000.
- R3: In user mode, an address in those windows faults with 0x040 for a read or 0x060 for a write. The exception is 0xE0000000..0xE3FFFFFF, which succeeds like R2. This check is made whether or not translation is enabled.
- R4: With `cfg_at`=0, any address outside the R2 windows succeeds for reads and writes with `rsp_pa` = `req_va[28:0]`.
- R5: On a single hit, `rsp_pa` is the entry's page number shifted up by 10 bits, with the bits below the page size taken from `req_va`. The page size code `ent_sz` selects the size: 0 is 1 KB, 1 is 4 KB, 2 is 64 KB and 3 is 1 MB. `ent_vpn` holds VA[31:10] and `ent_ppn` holds PA[28:10].
- R6: The tag `ent_asid` must equal `req_asid` only when `cfg_sv`=0 and `req_priv`=0. An entry with `ent_sh`=1 matches under any tag.
- R7: A translated lookup with no matching valid entry faults with 0x040 for a read or 0x060 for a write.
- R8: The access code `ent_pr` sets the permissions:
  - 00 and 01 give no access in user mode.
  - 00 is read-only in privileged mode, and 10 is read-only in both modes.
  - 01 is read-write in privileged mode, and 11 is read-write in both modes.
  - A denied read faults 0x0A0 and a denied write faults 0x0C0.
- R9: A permitted write to an entry with `ent_d`=0 faults 0x080. A write denied by R8 reports the R8 code instead.
- R10: When more than one entry matches, the lookup faults 0x140 for both reads and writes.
- R11: `tea` takes `req_va` on the same edge that a fault response is registered. It holds its value across successful responses.
- R12: `urc` changes only on a lookup that reaches the table, meaning `cfg_at`=1 and an address outside the R2 windows. On such a lookup it becomes the old value plus one, or 0 when that sum equals `cfg_urb` or 63. It never holds 63.
- R13: A slot write and a lookup in the same cycle both take effect. The lookup sees the table as it was before the write, and the new entry is matched from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_priv | input | 1 | 1 = privileged mode, 0 = user |
| req_asid | input | 8 | Current address-space tag |
| cfg_at | input | 1 | Translation enable |
| cfg_sv | input | 1 | Single address space: ignore tags |
| cfg_urb | input | 6 | Replacement counter boundary |
| ent_we | input | 1 | Table slot write strobe |
| ent_idx | input | 6 | Slot to write |
| ent_vpn | input | 22 | Virtual page, VA[31:10] |
| ent_ppn | input | 19 | Physical page, PA[28:10] |
| ent_asid | input | 8 | Entry address-space tag |
| ent_sz | input | 2 | Page size code |
| ent_pr | input | 2 | Access code |
| ent_v | input | 1 | Entry valid |
| ent_sh | input | 1 | Entry shared across tags |
| ent_d | input | 1 | Entry dirty |
| rsp_valid | output | 1 | Result strobe, one cycle after request |
| rsp_ok | output | 1 | Access permitted |
| rsp_pa | output | 29 | Physical address (0 on fault) |
| rsp_exc | output | 12 | Exception code (0 when permitted) |
| tea | output | 32 | Last faulting virtual address |
| urc | output | 6 | Replacement counter |

## Verification
The results `rsp_valid`, `rsp_ok`, `rsp_pa` and `rsp_exc` leave a single register stage, so they are due one rising edge after the request. The `tea` and `urc` registers update on that same edge. A slot write is matched starting with a request presented in the following cycle. The bench drives every request and slot write on a falling edge and samples 2 ns after the next rising edge. Each result is therefore read in the cycle it becomes due, never before and never a cycle late. The same-cycle write case samples at that same point to show the old table contents, then issues a second request to show the new entry.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

  localparam int VA_W     = 32;
  localparam int PA_W     = 29;
  localparam int PG_SHIFT = 10;
  localparam int VPN_W    = VA_W - PG_SHIFT;
  localparam int PPN_W    = PA_W - PG_SHIFT;
  localparam int ASID_W   = 8;
  localparam int EXC_W    = 12;

  localparam logic [EXC_W-1:0] EXC_NONE     = 12'h000;
  localparam logic [EXC_W-1:0] EXC_RD_MISS  = 12'h040;
  localparam logic [EXC_W-1:0] EXC_WR_MISS  = 12'h060;
  localparam logic [EXC_W-1:0] EXC_FIRST_WR = 12'h080;
  localparam logic [EXC_W-1:0] EXC_RD_PROT  = 12'h0A0;
  localparam logic [EXC_W-1:0] EXC_WR_PROT  = 12'h0C0;
  localparam logic [EXC_W-1:0] EXC_MULTI    = 12'h140;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RO   = 2'd1,
    ACC_RW   = 2'd2
  } access_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [ASID_W-1:0] asid;
    logic [1:0]        sz;
    logic [1:0]        pr;
    logic              sh;
    logic              d;
  } tlb_ent_t;

  // Mask of page-number bits (in 1 KB granules) that lie inside the page.
  function automatic logic [VPN_W-1:0] low_page_bits(input logic [1:0] sz);
    logic [VPN_W-1:0] m;
    case (sz)
      2'd0:    m = '0;
      2'd1:    m = VPN_W'(22'h3);
      2'd2:    m = VPN_W'(22'h3F);
      default: m = VPN_W'(22'h3FF);
    endcase
    return m;
  endfunction

endpackage

// File: rtl/utlb_array.sv
module utlb_array
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   widx,
  input  tlb_ent_t           wdata,
  input  logic               wvalid,
  input  logic [VPN_W-1:0]   look_vpn,
  input  logic [ASID_W-1:0]  look_asid,
  input  logic               use_asid,
  output logic [ENTRIES-1:0] match,
  output tlb_ent_t           hit_ent
);

  tlb_ent_t ent_arr [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic             v_q;
    tlb_ent_t         e_q;
    logic             sel;
    logic [VPN_W-1:0] lowm;
    logic             tag_ok;
    logic             addr_ok;

    assign sel = we && (widx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else if (sel) begin
        v_q <= wvalid;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        e_q <= wdata;
      end
    end

    assign lowm    = low_page_bits(e_q.sz);
    assign tag_ok  = !use_asid || e_q.sh || (e_q.asid == look_asid);
    assign addr_ok = ((look_vpn ^ e_q.vpn) & ~lowm) == '0;
    assign match[i]   = v_q && tag_ok && addr_ok;
    assign ent_arr[i] = e_q;
  end

  // OR-select: exact on a single hit; multiple hits are reported as faults.
  always_comb begin
    hit_ent = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (match[k]) begin
        hit_ent = tlb_ent_t'(hit_ent | ent_arr[k]);
      end
    end
  end

endmodule

// File: rtl/utlb_perm.sv
module utlb_perm
  import utlb_pkg::*;
(
  input  logic             priv,
  input  logic             is_write,
  input  logic [1:0]       pr,
  input  logic             dirty,
  output logic             ok,
  output logic [EXC_W-1:0] exc
);

  access_e acc;

  always_comb begin
    case ({pr, priv})
      3'b000, 3'b010:         acc = ACC_NONE;
      3'b001, 3'b100, 3'b101: acc = ACC_RO;
      default:                acc = ACC_RW;
    endcase
  end

  always_comb begin
    ok  = 1'b0;
    exc = EXC_NONE;
    if (acc == ACC_NONE) begin
      exc = is_write ? EXC_WR_PROT : EXC_RD_PROT;
    end else if (acc == ACC_RO && is_write) begin
      exc = EXC_WR_PROT;
    end else if (is_write && !dirty) begin
      exc = EXC_FIRST_WR;
    end else begin
      ok = 1'b1;
    end
  end

endmodule

// File: rtl/utlb_urc.sv
module utlb_urc #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [IDX_W-1:0] bound,
  output logic [IDX_W-1:0] count
);

  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] count_q;
  logic [IDX_W-1:0] count_n;
  logic [IDX_W-1:0] inc;

  always_comb begin
    inc     = count_q + IDX_W'(1);
    count_n = count_q;
    if (step) begin
      count_n = ((inc == bound) || (inc == LIMIT)) ? '0 : inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (step) begin
      count_q <= count_n;
    end
  end

  assign count = count_q;

endmodule

// File: rtl/utlb_xlate.sv
module utlb_xlate
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [31:0]        req_va,
  input  logic               req_write,
  input  logic               req_priv,
  input  logic [7:0]         req_asid,
  input  logic               cfg_at,
  input  logic               cfg_sv,
  input  logic [IDX_W-1:0]   cfg_urb,
  input  logic               ent_we,
  input  logic [IDX_W-1:0]   ent_idx,
  input  logic [21:0]        ent_vpn,
  input  logic [18:0]        ent_ppn,
  input  logic [7:0]         ent_asid,
  input  logic [1:0]         ent_sz,
  input  logic [1:0]         ent_pr,
  input  logic               ent_v,
  input  logic               ent_sh,
  input  logic               ent_d,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic [28:0]        rsp_pa,
  output logic [11:0]        rsp_exc,
  output logic [31:0]        tea,
  output logic [IDX_W-1:0]   urc
);

  // Region decode
  logic in_seg12, in_seg4, in_sq, fixed_map, use_asid, to_table;
  assign in_seg12  = req_va[31:30] == 2'b10;
  assign in_seg4   = req_va[31:29] == 3'b111;
  assign in_sq     = req_va[31:26] == 6'b111000;
  assign fixed_map = in_seg12 || in_seg4;
  assign use_asid  = !cfg_sv && !req_priv;
  assign to_table  = !fixed_map && cfg_at;

  // Table
  tlb_ent_t           wdata;
  logic [ENTRIES-1:0] match;
  tlb_ent_t           hit_ent;

  assign wdata = '{vpn: ent_vpn, ppn: ent_ppn, asid: ent_asid, sz: ent_sz,
                   pr: ent_pr, sh: ent_sh, d: ent_d};

  utlb_array #(.ENTRIES(ENTRIES)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (ent_we),
    .widx      (ent_idx),
    .wdata     (wdata),
    .wvalid    (ent_v),
    .look_vpn  (req_va[VA_W-1:PG_SHIFT]),
    .look_asid (req_asid),
    .use_asid  (use_asid),
    .match     (match),
    .hit_ent   (hit_ent)
  );

  logic             perm_ok;
  logic [EXC_W-1:0] perm_exc;

  utlb_perm u_perm (
    .priv     (req_priv),
    .is_write (req_write),
    .pr       (hit_ent.pr),
    .dirty    (hit_ent.d),
    .ok       (perm_ok),
    .exc      (perm_exc)
  );

  utlb_urc #(.ENTRIES(ENTRIES)) u_urc (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (req_valid && to_table),
    .bound (cfg_urb),
    .count (urc)
  );

  // Translated address
  logic [PPN_W-1:0] lowm;
  logic [PA_W-1:0]  xlat_pa;
  assign lowm    = low_page_bits(hit_ent.sz)[PPN_W-1:0];
  assign xlat_pa = {(hit_ent.ppn & ~lowm) | (req_va[PA_W-1:PG_SHIFT] & lowm),
                    req_va[PG_SHIFT-1:0]};

  // Result selection
  logic             multi, miss;
  logic             res_ok;
  logic [EXC_W-1:0] res_exc;
  logic [PA_W-1:0]  res_pa;

  assign multi = $countones(match) > 1;
  assign miss  = match == '0;

  always_comb begin
    res_ok  = 1'b0;
    res_exc = EXC_NONE;
    res_pa  = '0;
    if (fixed_map) begin
      if (!req_priv && !in_sq) begin
        res_exc = req_write ? EXC_WR_MISS : EXC_RD_MISS;
      end else begin
        res_ok = 1'b1;
        res_pa = req_va[PA_W-1:0];
      end
    end else if (!cfg_at) begin
      res_ok = 1'b1;
      res_pa = req_va[PA_W-1:0];
    end else if (multi) begin
      res_exc = EXC_MULTI;
    end else if (miss) begin
      res_exc = req_write ? EXC_WR_MISS : EXC_RD_MISS;
    end else begin
      res_ok  = perm_ok;
      res_exc = perm_exc;
      res_pa  = perm_ok ? xlat_pa : '0;
    end
  end

  // Response and fault-address registers
  logic             rsp_valid_q, rsp_ok_q;
  logic [PA_W-1:0]  rsp_pa_q;
  logic [EXC_W-1:0] rsp_exc_q;
  logic [VA_W-1:0]  tea_q;
  logic             tea_en;

  assign tea_en = req_valid && !res_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ok_q  <= 1'b0;
      rsp_pa_q  <= '0;
      rsp_exc_q <= EXC_NONE;
    end else if (req_valid) begin
      rsp_ok_q  <= res_ok;
      rsp_pa_q  <= res_pa;
      rsp_exc_q <= res_exc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tea_q <= '0;
    end else if (tea_en) begin
      tea_q <= req_va;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_ok    = rsp_ok_q;
  assign rsp_pa    = rsp_pa_q;
  assign rsp_exc   = rsp_exc_q;
  assign tea       = tea_q;

endmodule

// File: rtl/utlb_xlate_chk.sv
module utlb_xlate_chk #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [31:0]      req_va,
  input logic             req_write,
  input logic             req_priv,
  input logic             rsp_valid,
  input logic             rsp_ok,
  input logic [28:0]      rsp_pa,
  input logic [11:0]      rsp_exc,
  input logic [31:0]      tea,
  input logic [IDX_W-1:0] urc
);

  localparam logic [IDX_W-1:0] URC_TOP = IDX_W'(ENTRIES - 1);

  AST_URC_BELOW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    urc != URC_TOP); // R12

  AST_URC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> urc == $past(urc)); // R12

  AST_TEA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ok |-> tea == $past(req_va)); // R11

  AST_TEA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ok |-> tea == $past(tea)); // R11

  AST_FIXED_PA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ok && $past(req_va[31:30] == 2'b10)
      |-> rsp_pa == $past(req_va[28:0])); // R2

  AST_USER_FIXED_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(!req_priv && req_va[31:30] == 2'b10)
      |-> !rsp_ok && rsp_exc == ($past(req_write) ? 12'h060 : 12'h040)); // R3

  AST_FAULT_CODED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ok |-> rsp_exc != 12'h000); // R7

  AST_OK_UNCODED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ok |-> rsp_exc == 12'h000); // R2

endmodule

bind utlb_xlate utlb_xlate_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_va    (req_va),
  .req_write (req_write),
  .req_priv  (req_priv),
  .rsp_valid (rsp_valid),
  .rsp_ok    (rsp_ok),
  .rsp_pa    (rsp_pa),
  .rsp_exc   (rsp_exc),
  .tea       (tea),
  .urc       (urc)
);

// File: tb/sim_utlb_xlate.sv
`timescale 1ns/1ps
module sim_utlb_xlate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_priv;
  logic [31:0] req_va;
  logic [7:0]  req_asid;
  logic        cfg_at, cfg_sv;
  logic [5:0]  cfg_urb;
  logic        ent_we;
  logic [5:0]  ent_idx;
  logic [21:0] ent_vpn;
  logic [18:0] ent_ppn;
  logic [7:0]  ent_asid;
  logic [1:0]  ent_sz, ent_pr;
  logic        ent_v, ent_sh, ent_d;
  logic        rsp_valid, rsp_ok;
  logic [28:0] rsp_pa;
  logic [11:0] rsp_exc;
  logic [31:0] tea;
  logic [5:0]  urc;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [5:0] exp_urc;
  logic        got_valid, got_ok;
  logic [28:0] got_pa;
  logic [11:0] got_exc;

  always #4 clk = ~clk;

  utlb_xlate u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic is_fixed(input logic [31:0] va);
    return (va[31:30] == 2'b10) || (va[31:29] == 3'b111);
  endfunction

  function automatic logic [5:0] urc_next(input logic [5:0] c, input logic [5:0] b);
    logic [5:0] n;
    n = c + 6'd1;
    return (n == b || n == 6'd63) ? 6'd0 : n;
  endfunction

  task automatic look(input logic [31:0] va, input logic wr, input logic prv, input logic [7:0] asid);
    @(negedge clk);
    req_va = va; req_write = wr; req_priv = prv; req_asid = asid; req_valid = 1'b1;
    if (cfg_at && !is_fixed(va)) exp_urc = urc_next(exp_urc, cfg_urb);
    @(posedge clk); #2;
    req_valid = 1'b0;
    got_valid = rsp_valid; got_ok = rsp_ok; got_pa = rsp_pa; got_exc = rsp_exc;
  endtask

  task automatic put(input int idx, input logic [31:0] va, input logic [31:0] pa,
                     input logic [7:0] asid, input logic [1:0] sz, input logic [1:0] pr,
                     input logic sh, input logic d);
    ent_idx = 6'(idx); ent_vpn = va[31:10]; ent_ppn = pa[28:10]; ent_asid = asid;
    ent_sz = sz; ent_pr = pr; ent_v = 1'b1; ent_sh = sh; ent_d = d;
  endtask

  task automatic wr_ent(input int idx, input logic [31:0] va, input logic [31:0] pa,
                        input logic [7:0] asid, input logic [1:0] sz, input logic [1:0] pr,
                        input logic sh, input logic d);
    @(negedge clk);
    put(idx, va, pa, asid, sz, pr, sh, d);
    ent_we = 1'b1;
    @(posedge clk); #1;
    ent_we = 1'b0;
  endtask

  task automatic expect_ok(input string tag, input logic [28:0] pa);
    chk({tag, " valid"}, 32'(got_valid), 32'd1);
    chk({tag, " ok"}, 32'(got_ok), 32'd1);
    chk({tag, " pa"}, 32'(got_pa), 32'(pa));
  endtask

  task automatic expect_fault(input string tag, input logic [11:0] code, input logic [31:0] va);
    chk({tag, " ok"}, 32'(got_ok), 32'd0);
    chk({tag, " exc"}, 32'(got_exc), 32'(code));
    chk({tag, " tea R11"}, tea, va);
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 urc", 32'(urc), 32'd0);
    chk("R1 tea", tea, 32'd0);
    look(32'h0000_1000, 1'b0, 1'b1, 8'd0);
    expect_fault("R1 empty table", 12'h040, 32'h0000_1000);
    chk("R12 urc after first lookup", 32'(urc), 32'd1);
  endtask

  task automatic t_urc;
    cfg_urb = 6'd3;
    look(32'h0000_2000, 1'b0, 1'b1, 8'd0);
    chk("R12 urc step", 32'(urc), 32'd2);
    look(32'h0000_2000, 1'b0, 1'b1, 8'd0);
    chk("R12 urc wraps at boundary", 32'(urc), 32'd0);
    cfg_urb = 6'd0;
    for (int i = 0; i < 62; i++) look(32'h0000_3000, 1'b1, 1'b1, 8'd0);
    chk("R12 urc reaches 62", 32'(urc), 32'd62);
    look(32'h0000_3000, 1'b0, 1'b1, 8'd0);
    chk("R12 urc wraps before 63", 32'(urc), 32'd0);
    chk("R12 urc model", 32'(urc), 32'(exp_urc));
  endtask

  task automatic t_fixed;
    look(32'h8123_4567, 1'b0, 1'b1, 8'd0);
    expect_ok("R2 seg read", 29'h0123_4567);
    look(32'hF000_0010, 1'b1, 1'b1, 8'd0);
    expect_ok("R2 top seg write", 29'h1000_0010);
    look(32'h8000_0000, 1'b0, 1'b0, 8'd0);
    expect_fault("R3 user read", 12'h040, 32'h8000_0000);
    look(32'hA000_0004, 1'b1, 1'b0, 8'd0);
    expect_fault("R3 user write", 12'h060, 32'hA000_0004);
    look(32'hE3FF_FFFC, 1'b1, 1'b0, 8'd0);
    expect_ok("R3 store queue", 29'h03FF_FFFC);
    look(32'hE400_0000, 1'b0, 1'b0, 8'd0);
    expect_fault("R3 above store queue", 12'h040, 32'hE400_0000);
    chk("R12 urc untouched by fixed regions", 32'(urc), 32'(exp_urc));
  endtask

  task automatic t_at_off;
    cfg_at = 1'b0;
    look(32'h7234_5678, 1'b1, 1'b0, 8'd3);
    expect_ok("R4 write passthrough", 29'h1234_5678);
    look(32'h0000_0040, 1'b0, 1'b0, 8'd3);
    expect_ok("R4 read passthrough", 29'h0000_0040);
    look(32'h9000_0000, 1'b0, 1'b0, 8'd3);
    expect_fault("R3 user region with AT off", 12'h040, 32'h9000_0000);
    chk("R12 urc untouched with AT off", 32'(urc), 32'(exp_urc));
    cfg_at = 1'b1;
  endtask

  task automatic t_sizes;
    wr_ent(0, 32'h0040_0000, 32'h0ABC_D000, 8'd0, 2'd1, 2'b11, 1'b1, 1'b1);
    wr_ent(1, 32'h1000_0000, 32'h0050_0000, 8'd0, 2'd3, 2'b11, 1'b1, 1'b1);
    wr_ent(2, 32'h2000_0400, 32'h0000_0800, 8'd0, 2'd0, 2'b11, 1'b1, 1'b1);
    wr_ent(14, 32'h5100_0000, 32'h0033_0000, 8'd0, 2'd2, 2'b11, 1'b1, 1'b1);
    look(32'h0040_0123, 1'b0, 1'b1, 8'd0);
    expect_ok("R5 4K page", 29'h0ABC_D123);
    look(32'h100F_FFFC, 1'b1, 1'b1, 8'd0);
    expect_ok("R5 1M page", 29'h005F_FFFC);
    look(32'h2000_07FF, 1'b0, 1'b1, 8'd0);
    expect_ok("R5 1K page", 29'h0000_0BFF);
    look(32'h2000_0800, 1'b0, 1'b1, 8'd0);
    expect_fault("R5 1K page end", 12'h040, 32'h2000_0800);
    look(32'h5100_ABCD, 1'b0, 1'b1, 8'd0);
    expect_ok("R5 64K page", 29'h0033_ABCD);
    chk("R12 urc model", 32'(urc), 32'(exp_urc));
  endtask

  task automatic t_asid;
    wr_ent(3, 32'h3000_0000, 32'h0100_0000, 8'd5, 2'd1, 2'b11, 1'b0, 1'b1);
    wr_ent(4, 32'h3100_0000, 32'h0110_0000, 8'd9, 2'd1, 2'b11, 1'b1, 1'b1);
    look(32'h3000_0010, 1'b0, 1'b0, 8'd5);
    expect_ok("R6 tag equal", 29'h0100_0010);
    look(32'h3000_0010, 1'b0, 1'b0, 8'd6);
    expect_fault("R6 tag differs", 12'h040, 32'h3000_0010);
    look(32'h3000_0020, 1'b0, 1'b1, 8'd6);
    expect_ok("R6 privileged ignores tag", 29'h0100_0020);
    cfg_sv = 1'b1;
    look(32'h3000_0030, 1'b0, 1'b0, 8'd6);
    expect_ok("R6 single space ignores tag", 29'h0100_0030);
    cfg_sv = 1'b0;
    look(32'h3100_0040, 1'b0, 1'b0, 8'd2);
    expect_ok("R6 shared entry", 29'h0110_0040);
  endtask

  task automatic t_miss;
    look(32'h5000_0000, 1'b0, 1'b1, 8'd0);
    expect_fault("R7 read miss", 12'h040, 32'h5000_0000);
    look(32'h5000_1000, 1'b1, 1'b0, 8'd0);
    expect_fault("R7 write miss", 12'h060, 32'h5000_1000);
  endtask

  task automatic t_prot;
    wr_ent(5, 32'h4000_0000, 32'h0200_0000, 8'd0, 2'd1, 2'b00, 1'b1, 1'b1);
    wr_ent(6, 32'h4001_0000, 32'h0201_0000, 8'd0, 2'd1, 2'b01, 1'b1, 1'b1);
    wr_ent(7, 32'h4002_0000, 32'h0202_0000, 8'd0, 2'd1, 2'b10, 1'b1, 1'b1);
    wr_ent(8, 32'h4003_0000, 32'h0203_0000, 8'd0, 2'd1, 2'b11, 1'b1, 1'b1);
    look(32'h4000_0000, 1'b0, 1'b0, 8'd0);
    expect_fault("R8 pr00 user read", 12'h0A0, 32'h4000_0000);
    look(32'h4000_0004, 1'b0, 1'b1, 8'd0);
    expect_ok("R8 pr00 priv read", 29'h0200_0004);
    look(32'h4000_0008, 1'b1, 1'b1, 8'd0);
    expect_fault("R8 pr00 priv write", 12'h0C0, 32'h4000_0008);
    look(32'h4001_0000, 1'b1, 1'b0, 8'd0);
    expect_fault("R8 pr01 user write", 12'h0C0, 32'h4001_0000);
    look(32'h4001_0004, 1'b1, 1'b1, 8'd0);
    expect_ok("R8 pr01 priv write", 29'h0201_0004);
    look(32'h4002_0008, 1'b0, 1'b0, 8'd0);
    expect_ok("R8 pr10 user read", 29'h0202_0008);
    look(32'h4002_000C, 1'b1, 1'b1, 8'd0);
    expect_fault("R8 pr10 priv write", 12'h0C0, 32'h4002_000C);
    look(32'h4003_0010, 1'b1, 1'b0, 8'd0);
    expect_ok("R8 pr11 user write", 29'h0203_0010);
  endtask

  task automatic t_dirty;
    wr_ent(9, 32'h4004_0000, 32'h0204_0000, 8'd0, 2'd1, 2'b11, 1'b1, 1'b0);
    wr_ent(10, 32'h4005_0000, 32'h0205_0000, 8'd0, 2'd1, 2'b10, 1'b1, 1'b0);
    look(32'h4004_0100, 1'b1, 1'b0, 8'd0);
    expect_fault("R9 clean page write", 12'h080, 32'h4004_0100);
    look(32'h4004_0104, 1'b0, 1'b0, 8'd0);
    expect_ok("R9 clean page read", 29'h0204_0104);
    look(32'h4005_0000, 1'b1, 1'b1, 8'd0);
    expect_fault("R9 violation beats clean", 12'h0C0, 32'h4005_0000);
  endtask

  task automatic t_multi;
    wr_ent(11, 32'h6000_0000, 32'h0300_0000, 8'd0, 2'd3, 2'b11, 1'b1, 1'b1);
    wr_ent(12, 32'h6000_1000, 32'h0310_0000, 8'd0, 2'd1, 2'b11, 1'b1, 1'b1);
    look(32'h6000_1004, 1'b0, 1'b1, 8'd0);
    expect_fault("R10 multi read", 12'h140, 32'h6000_1004);
    look(32'h6000_1008, 1'b1, 1'b0, 8'd0);
    expect_fault("R10 multi write", 12'h140, 32'h6000_1008);
    look(32'h6000_2000, 1'b0, 1'b1, 8'd0);
    expect_ok("R10 single hit beside", 29'h0300_2000);
  endtask

  task automatic t_tea;
    look(32'h5555_0000, 1'b0, 1'b1, 8'd0);
    expect_fault("R11 capture", 12'h040, 32'h5555_0000);
    look(32'h0040_0200, 1'b0, 1'b1, 8'd0);
    chk("R11 hold on success", tea, 32'h5555_0000);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    put(13, 32'h7000_0000, 32'h0400_0000, 8'd0, 2'd1, 2'b11, 1'b1, 1'b1);
    ent_we = 1'b1;
    req_va = 32'h7000_0044; req_write = 1'b0; req_priv = 1'b1; req_asid = 8'd0;
    req_valid = 1'b1;
    exp_urc = urc_next(exp_urc, cfg_urb);
    @(posedge clk); #2;
    ent_we = 1'b0; req_valid = 1'b0;
    got_ok = rsp_ok; got_exc = rsp_exc;
    expect_fault("R13 lookup sees old table", 12'h040, 32'h7000_0044);
    look(32'h7000_0044, 1'b0, 1'b1, 8'd0);
    expect_ok("R13 entry next cycle", 29'h0400_0044);
    chk("R12 urc model final", 32'(urc), 32'(exp_urc));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_va = '0; req_write = 1'b0; req_priv = 1'b0; req_asid = '0;
    cfg_at = 1'b1; cfg_sv = 1'b0; cfg_urb = 6'd0;
    ent_we = 1'b0; ent_idx = '0; ent_vpn = '0; ent_ppn = '0; ent_asid = '0;
    ent_sz = '0; ent_pr = '0; ent_v = 1'b0; ent_sh = 1'b0; ent_d = 1'b0;
    exp_urc = 6'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset;
    t_urc;
    t_fixed;
    t_at_off;
    t_sizes;
    t_asid;
    t_miss;
    t_prot;
    t_dirty;
    t_multi;
    t_tea;
    t_same_cycle;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule